// File: doc/BRIEF.md
# Pipelined Burst SRAM with Dual Address Strobes

This block is a synchronous single-port memory with a pipelined read path. Every control, address and data input is sampled on the rising clock edge. Read data comes out of an output register. Words are 36 bits wide and are split into four 9-bit byte lanes. The depth is a parameter. An access can be opened by a processor-side strobe or by a controller-side strobe. Three chip selects must all be active for a strobe to open an access. A strobe that arrives while the selects are not all active closes the device instead.

Once an access is open, an advance input walks a 2-bit burst counter through a group of four words. The order is linear or interleaved, chosen when the strobe is sampled. If neither strobe nor advance is asserted, the current word is accessed again, which suspends the burst. Writes can be done per lane under a lane-write enable. A global write stores all lanes. The data bus is split into separate write and read ports. A drive-enable output tells the pad ring when the read port owns the bus. That enable follows an asynchronous output-enable pin and is masked on the first clock of a read that leaves the deselected state.

Top module: `sync_burst_sram`

## Requirements
- R1: Inputs are sampled on the rising edge, and a read's word appears on `rdata` with `rdrive` high after the second rising edge, counting the edge that sampled the access.
- R2: When all selects are active, a low level on either strobe opens an access at `addr`. The processor strobe takes priority if both are low, and a processor-strobe cycle is always a read that ignores the write controls.
- R3: A controller-strobe cycle with write controls asserted writes `wdata` at `addr` in that same cycle.
- R4: With no strobe and `adv_n` low, the access moves to the next burst word, which stays inside the aligned group of four. The low two address bits are (start + n) mod 4 when `burst_linear` = 1 and start XOR n when it is 0, where n counts advances modulo 4.
- R5: With no strobe and `adv_n` high, the same word as in the previous cycle is read or written again.
- R6: Lane g is bits 9g+8..9g. When `wr_lane_en_n` is low, the lanes whose `lane_sel_n` bit is low are written and the other lanes keep their contents. When both write enables are high, the cycle is a read, whatever the state of `lane_sel_n`.
- R7: A low `wr_all_n` writes all four lanes, whatever the state of `wr_lane_en_n` and `lane_sel_n`.
- R8: The device is selected only when `sel_a_n` = 0, `sel_b` = 1 and `sel_c_n` = 0. A strobe under any other combination performs no access, and no advance or suspend cycle accesses memory until a selected strobe arrives.
- R9: Deselect takes one cycle. The read data already in flight is still driven in the cycle after the deselecting edge, and `rdrive` is low after the following edge.
- R10: `oe_n` acts without a clock. While it is high, `rdrive` is low. When it goes low again, the drive returns at once if read data is present.
- R11: In the cycle after a read is opened from the deselected state, `rdrive` stays low even with `oe_n` low.
- R12: A write followed on the next cycle by a read of the same address returns the new data.
- R13: When reset is asserted, `rdrive` and `rdata` go to zero and the device is deselected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| strb_cpu_n | input | 1 | Processor-side access strobe, active low |
| strb_ctl_n | input | 1 | Controller-side access strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_lane_en_n | input | 1 | Enable for per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Output register contents |
| rdrive | output | 1 | Read port owns the bus |

## Verification
The main path is exercised in several ways:
- Single-word writes opened by the controller strobe and then read back through both burst orders from a mid-group start. This separates linear from interleaved order and shows the wrap inside the group of four.
- Suspend cycles repeated after advances. These show that holding the address differs from stepping it.
- A processor strobe issued with the global write asserted. It must still return the old word, which separates the two strobes.
- Lane patterns with only some lane selects low, a pattern with the lane enable off, and a global write with all selects high. These tell the three write-qualification rules apart.
- Directed sequences that cover a deselect in the middle of a read stream, a read reopened after deselect, clockless toggling of the output enable, and a reset during activity.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  localparam int BURST_W = 2;

  // Offset of burst word `step` for a burst whose first word sits at `start`.
  function automatic logic [BURST_W-1:0] burst_offset(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input logic               linear
  );
    if (linear) return start + step;
    return start ^ step;
  endfunction

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int AW     = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_all_n,
  input  logic              wr_lane_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              burst_linear,
  input  logic [WORD_W-1:0] wdata,
  output op_e               s1_op,
  output logic [AW-1:0]     s1_addr,
  output logic [LANES-1:0]  s1_mask,
  output logic [WORD_W-1:0] s1_data,
  output logic              s1_first_rd
);

  function automatic logic [LANES-1:0] lanes_to_write(
    input logic             all_n,
    input logic             en_n,
    input logic [LANES-1:0] sel_n
  );
    if (!all_n) return '1;
    if (!en_n)  return ~sel_n;
    return '0;
  endfunction

  logic               active_q;
  logic [AW-1:0]      base_q;
  logic [BURST_W-1:0] step_q;
  logic               lin_q;

  // Named events for the checks below.
  logic any_strobe, selected;
  logic evt_start, evt_desel, evt_adv, evt_hold;

  logic [BURST_W-1:0] step_nxt;
  logic [LANES-1:0]   wmask;
  op_e                op_nxt;
  logic [AW-1:0]      addr_nxt;
  logic [LANES-1:0]   mask_nxt;
  logic               first_nxt;

  always_comb begin
    any_strobe = !strb_cpu_n || !strb_ctl_n;
    selected   = !sel_a_n && sel_b && !sel_c_n;
    evt_start  = any_strobe && selected;
    evt_desel  = any_strobe && !selected;
    evt_adv    = !any_strobe && active_q && !adv_n;
    evt_hold   = !any_strobe && active_q && adv_n;
    step_nxt   = evt_adv ? step_q + 1'b1 : step_q;
    wmask      = lanes_to_write(wr_all_n, wr_lane_en_n, lane_sel_n);

    op_nxt   = OP_IDLE;
    addr_nxt = s1_addr;
    mask_nxt = '0;
    if (evt_start) begin
      addr_nxt = addr;
      if (!strb_cpu_n || (wmask == '0)) begin
        op_nxt = OP_READ;
      end else begin
        op_nxt   = OP_WRITE;
        mask_nxt = wmask;
      end
    end else if (evt_adv || evt_hold) begin
      addr_nxt = {base_q[AW-1:BURST_W], burst_offset(base_q[BURST_W-1:0], step_nxt, lin_q)};
      if (wmask == '0) begin
        op_nxt = OP_READ;
      end else begin
        op_nxt   = OP_WRITE;
        mask_nxt = wmask;
      end
    end
    first_nxt = evt_start && (op_nxt == OP_READ) && !active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      base_q      <= '0;
      step_q      <= '0;
      lin_q       <= 1'b1;
      s1_op       <= OP_IDLE;
      s1_addr     <= '0;
      s1_mask     <= '0;
      s1_first_rd <= 1'b0;
    end else begin
      s1_op       <= op_nxt;
      s1_addr     <= addr_nxt;
      s1_mask     <= mask_nxt;
      s1_first_rd <= first_nxt;
      if (evt_start) begin
        active_q <= 1'b1;
        base_q   <= addr;
        step_q   <= '0;
        lin_q    <= burst_linear;
      end else if (evt_desel) begin
        active_q <= 1'b0;
      end else if (evt_adv) begin
        step_q <= step_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    s1_data <= wdata;
  end

  // R8: a strobe without full selection opens nothing
  a_r8_desel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_desel |=> (s1_op == OP_IDLE));

  // R2: processor strobe cycle is a read with no lanes written
  a_r2_cpu_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_start && !strb_cpu_n) |=> (s1_op == OP_READ && s1_mask == '0));

  // R5: a suspend cycle repeats the previous word
  a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hold |=> $stable(s1_addr));

  // R4: an advance moves to another word
  a_r4_adv_moves: assert property (@(posedge clk) disable iff (!rst_n)
    evt_adv |=> (s1_addr != $past(s1_addr)));

  // R4: an advance stays inside the aligned group of four
  a_r4_adv_group: assert property (@(posedge clk) disable iff (!rst_n)
    evt_adv |=> (s1_addr[AW-1:BURST_W] == $past(s1_addr[AW-1:BURST_W])));

endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int DEPTH  = 512,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW     = $clog2(DEPTH),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [LANES-1:0]  mask,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] rd_q
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_en && mask[g]) cells[addr] <= data[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lane_q <= '0;
      else if (rd_en) lane_q <= cells[addr];
    end

    assign rd_q[g*LANE_W +: LANE_W] = lane_q;
  end

  // R3: one stage never both writes and reads
  a_r3_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

endmodule

// File: rtl/sram_drive.sv
module sram_drive
  import sram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  s1_op,
  input  logic s1_first_rd,
  input  logic oe_n,
  output logic rdrive
);

  logic valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= (s1_op == OP_READ);
  end

  assign rdrive = valid_q && !s1_first_rd && !oe_n;

  // R9: an empty stage leaves the bus released one edge later
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_IDLE) |=> !rdrive);

  // R11: no drive in the first cycle of a read opened from deselect
  a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
    s1_first_rd |-> !rdrive);

  // R10: output enable gates the drive
  a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdrive);

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW     = $clog2(DEPTH),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_all_n,
  input  logic              wr_lane_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              burst_linear,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rdrive
);

  op_e               s1_op;
  logic [AW-1:0]     s1_addr;
  logic [LANES-1:0]  s1_mask;
  logic [WORD_W-1:0] s1_data;
  logic              s1_first_rd;
  logic              st_wr, st_rd;

  sram_ctrl #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk, .rst_n, .addr, .strb_cpu_n, .strb_ctl_n, .adv_n,
    .sel_a_n, .sel_b, .sel_c_n, .wr_all_n, .wr_lane_en_n, .lane_sel_n,
    .burst_linear, .wdata,
    .s1_op, .s1_addr, .s1_mask, .s1_data, .s1_first_rd
  );

  assign st_wr = (s1_op == OP_WRITE);
  assign st_rd = (s1_op == OP_READ);

  sram_store #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk, .rst_n, .wr_en(st_wr), .rd_en(st_rd), .addr(s1_addr),
    .mask(s1_mask), .data(s1_data), .rd_q(rdata)
  );

  sram_drive u_drive (
    .clk, .rst_n, .s1_op, .s1_first_rd, .oe_n, .rdrive
  );

  // R1: a read in the stage yields a driven word one edge later when enabled
  a_r1_read_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !s1_first_rd && !oe_n) |=> (oe_n || rdrive));

endmodule

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;
  localparam int DEPTH = 512;
  localparam int LANES = 4;
  localparam int LANE_W = 9;
  localparam int AW = 9;
  localparam int WW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
  logic sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic wr_all_n = 1'b1, wr_lane_en_n = 1'b1;
  logic [LANES-1:0] lane_sel_n = '1;
  logic burst_linear = 1'b1, oe_n = 1'b0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic rdrive;

  int checks = 0;
  int errors = 0;

  sync_burst_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk, .rst_n, .addr, .strb_cpu_n, .strb_ctl_n, .adv_n,
    .sel_a_n, .sel_b, .sel_c_n, .wr_all_n, .wr_lane_en_n, .lane_sel_n,
    .burst_linear, .oe_n, .wdata, .rdata, .rdrive
  );

  always #2.5 clk = ~clk;

  localparam logic [WW-1:0] WA = 36'hA_5A5A_5A5A;
  localparam logic [WW-1:0] WB = 36'h5_A5A5_A5A5;
  localparam logic [WW-1:0] C0 = 36'h1_1111_1111;
  localparam logic [WW-1:0] C1 = 36'h2_2222_2222;
  localparam logic [WW-1:0] C2 = 36'h3_3333_3333;
  localparam logic [WW-1:0] C3 = 36'h4_4444_4444;
  localparam logic [WW-1:0] WD = 36'hF_EDCB_A987;
  localparam logic [WW-1:0] WE = 36'h9_8765_4321;
  localparam logic [WW-1:0] JK = 36'hD_EADB_EEF0;
  // lanes 0 and 2 written by select pattern 4'b1010
  localparam logic [WW-1:0] LM = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
  localparam logic [WW-1:0] WM = (WD & LM) | (C0 & ~LM);

  // kind: 0 none, 1 processor strobe, 2 controller strobe
  // wr: 0 none, 1 lane enable low, 2 global low, 3 selects low but enable high
  // drv/exp: outputs seen one clock later (result of the previous row)
  typedef struct packed {
    logic [1:0]    kind;
    logic [AW-1:0] adr;
    logic          adv;
    logic          sel;
    logic          lin;
    logic [1:0]    wr;
    logic [3:0]    lsn;
    logic [WW-1:0] wd;
    logic          drv;
    logic [WW-1:0] exp;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{2'd2, 9'h010, 1'b1, 1'b1, 1'b1, 2'd2, 4'hF, WA, 1'b0, '0, 8'd13}, // R13 R3
    '{2'd0, 9'h000, 1'b0, 1'b1, 1'b1, 2'd2, 4'hF, WB, 1'b0, '0, 8'd3},  // R4 write after advance
    '{2'd1, 9'h010, 1'b1, 1'b1, 1'b1, 2'd2, 4'h0, JK, 1'b0, '0, 8'd2},  // R2 write ctl ignored
    '{2'd0, 9'h000, 1'b0, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b1, WA, 8'd1},  // R1 R2
    '{2'd0, 9'h000, 1'b1, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b1, WB, 8'd4},  // R4
    '{2'd2, 9'h020, 1'b1, 1'b1, 1'b1, 2'd2, 4'hF, C0, 1'b1, WB, 8'd5},  // R5
    '{2'd2, 9'h021, 1'b1, 1'b1, 1'b1, 2'd2, 4'hF, C1, 1'b0, '0, 8'd3},
    '{2'd2, 9'h022, 1'b1, 1'b1, 1'b1, 2'd2, 4'hF, C2, 1'b0, '0, 8'd3},
    '{2'd2, 9'h023, 1'b1, 1'b1, 1'b1, 2'd2, 4'hF, C3, 1'b0, '0, 8'd3},
    '{2'd2, 9'h022, 1'b1, 1'b1, 1'b0, 2'd0, 4'hF, '0, 1'b0, '0, 8'd3},  // interleaved start 2
    '{2'd0, 9'h000, 1'b0, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b1, C2, 8'd4},
    '{2'd0, 9'h000, 1'b0, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b1, C3, 8'd4},
    '{2'd0, 9'h000, 1'b0, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b1, C0, 8'd4},
    '{2'd0, 9'h000, 1'b0, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b1, C1, 8'd4},
    '{2'd2, 9'h023, 1'b1, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b1, C2, 8'd4},  // linear start 3
    '{2'd0, 9'h000, 1'b0, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b1, C3, 8'd4},
    '{2'd0, 9'h000, 1'b0, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b1, C0, 8'd4},
    '{2'd2, 9'h020, 1'b1, 1'b1, 1'b1, 2'd1, 4'hA, WD, 1'b1, C1, 8'd4},  // R6 lanes 0,2
    '{2'd2, 9'h020, 1'b1, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b0, '0, 8'd6},
    '{2'd0, 9'h000, 1'b1, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b1, WM, 8'd12}, // R12 R6
    '{2'd2, 9'h021, 1'b1, 1'b1, 1'b1, 2'd3, 4'h0, JK, 1'b1, WM, 8'd5},  // R5
    '{2'd2, 9'h021, 1'b1, 1'b1, 1'b1, 2'd2, 4'hF, WE, 1'b1, C1, 8'd6},  // R6 no write
    '{2'd2, 9'h021, 1'b1, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b0, '0, 8'd7},
    '{2'd0, 9'h000, 1'b1, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b1, WE, 8'd7},  // R7
    '{2'd2, 9'h000, 1'b1, 1'b0, 1'b1, 2'd0, 4'hF, '0, 1'b1, WE, 8'd9},  // R9 still driven
    '{2'd0, 9'h000, 1'b0, 1'b1, 1'b1, 2'd2, 4'hF, JK, 1'b0, '0, 8'd9},  // R9 released
    '{2'd0, 9'h000, 1'b1, 1'b1, 1'b1, 2'd0, 4'hF, '0, 1'b0, '0, 8'd8}   // R8 no access
  };

  task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    strb_cpu_n   = !(v.kind == 2'd1);
    strb_ctl_n   = !(v.kind == 2'd2);
    addr         = v.adr;
    adv_n        = v.adv;
    sel_a_n      = 1'b0;
    sel_b        = v.sel;
    sel_c_n      = 1'b0;
    burst_linear = v.lin;
    wr_all_n     = !(v.wr == 2'd2);
    wr_lane_en_n = !(v.wr == 2'd1);
    lane_sel_n   = v.lsn;
    wdata        = v.wd;
  endtask

  function automatic vec_t mk(input logic [1:0] kind, input logic [AW-1:0] adr,
                              input logic adv, input logic sel);
    vec_t v;
    v = '0;
    v.kind = kind; v.adr = adr; v.adv = adv; v.sel = sel;
    v.lin = 1'b1; v.lsn = 4'hF;
    return v;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    apply(mk(2'd0, '0, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    check("R13 reset rdrive", {35'd0, rdrive}, '0);
    check("R13 reset rdata", rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      step();
      check($sformatf("R%0d row %0d rdrive", TBL[i].req, i), {35'd0, rdrive}, {35'd0, TBL[i].drv});
      if (TBL[i].drv) check($sformatf("R%0d row %0d rdata", TBL[i].req, i), rdata, TBL[i].exp);
    end

    // R11: read reopened from the deselected state
    apply(mk(2'd2, 9'h010, 1'b1, 1'b1));
    step();
    check("R11 masked first cycle", {35'd0, rdrive}, '0);
    apply(mk(2'd0, '0, 1'b1, 1'b1));
    step();
    check("R1 reopened read drive", {35'd0, rdrive}, 36'd1);
    check("R1 reopened read data", rdata, WA);

    // R10: output enable without a clock edge
    #0.5 oe_n = 1'b1;
    #0.5 check("R10 oe high releases", {35'd0, rdrive}, '0);
    #0.5 oe_n = 1'b0;
    #0.5 check("R10 oe low restores", {35'd0, rdrive}, 36'd1);

    // R8: processor strobe with one select inactive
    @(negedge clk);
    apply(mk(2'd1, 9'h011, 1'b1, 1'b0));
    step();
    check("R9 data held one cycle", {35'd0, rdrive}, 36'd1);
    apply(mk(2'd0, '0, 1'b0, 1'b1));
    step();
    check("R8 deselected strobe no read", {35'd0, rdrive}, '0);
    step();
    check("R8 advance while deselected", {35'd0, rdrive}, '0);

    // R13: reset during an active read stream
    apply(mk(2'd2, 9'h011, 1'b1, 1'b1));
    step();
    apply(mk(2'd0, '0, 1'b1, 1'b1));
    step();
    check("R12 read before reset", rdata, WB);
    #0.5 rst_n = 1'b0;
    #0.5 check("R13 reset drops drive", {35'd0, rdrive}, '0);
    check("R13 reset clears data", rdata, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    check("R13 stays deselected", {35'd0, rdrive}, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule